// File: doc/BRIEF.md
# Jumbo prefix combiner

This block sits between instruction decode and execute. It receives one 32-bit instruction word per cycle and watches for prefix words. A prefix is never executed. Its 24-bit payload goes into an internal slot, and the slot in the pipeline becomes a bubble that execute treats as a no-operation and that an interrupt may not land on. The next real instruction is merged with the stored payloads. The merge either widens that instruction's immediate or attaches an opcode extension.

There are two kinds of prefix. One that starts with byte `FE` extends an immediate. One that starts with byte `FF` extends an opcode. At most two prefixes can be chained, and only two `FE` prefixes in a row are allowed. Depending on the prefix kind, the 24-bit constant words `FA` and `FB` turn into 48-bit constant loads into R0 or into 48-bit absolute jumps and calls. Chains that no instruction form accepts are flagged as invalid. The pending state is dropped whenever an instruction issues and whenever the pipeline flushes, so a stale payload cannot merge into an unrelated instruction.

The outputs are combinational from the current word and the pending state. Pending state changes only at the clock edge.

Top module: `jumbo_combiner`

## Requirements
- R1: After reset no payload is pending, so a constant word arriving right after reset decodes without a prefix. While `valid_i` is low, every output is 0.
- R2: An accepted prefix word gives `valid_o`=1, `bubble_o`=1, `irq_ok_o`=0, `kind_o`=0 and `imm_o`=0. A prefix is accepted when nothing is pending, or when it is an `FE` word following exactly one pending `FE` word.
- R3: `FE` then `FA` gives kind 3 (move to R0) with `imm_o` = {16'h0000, payload, word[23:0]}. `FE` then `FB` gives kind 3 with the upper 16 bits set to all ones.
- R4: `FF` then `FA` gives kind 4 (absolute jump), and `FF` then `FB` gives kind 5 (absolute call). In both cases `imm_o` = {16'h0000, payload, word[23:0]}.
- R5: `FE`, `FE`, then an `F8` word gives kind 2 with `imm_o` = {first payload, second payload, word[15:0]}.
- R6: One `FE` before an `F1` or `F2` word gives kind 2 with `imm_o` equal to {payload, word[8:0]} sign-extended from bit 32.
- R7: Unprefixed words decode as follows:
  - `F1`/`F2` give kind 2 with word[8:0] sign-extended.
  - `F8` gives kind 2 with word[15:0] sign-extended.
  - `FA` gives kind 3 with word[23:0] zero-extended.
  - `FB` gives kind 3 with word[23:0] and ones above.
  - `F0` and any other non-prefix word give kind 1 (plain) with `imm_o`=0.
- R8: One `FF` before an `F0`, `F1`, `F2` or `F8` word gives the unprefixed result plus `opx_valid_o`=1 and `opx_o` = payload.
- R9: Two `FE` prefixes before an `F1` or `F2` word (a 57-bit form) give `illegal_o`=1, `kind_o`=0 and `imm_o`=0.
- R10: Each of the following gives `illegal_o`=1 with `bubble_o`=0:
  - a third consecutive prefix;
  - an `FF` after a pending prefix;
  - an `FE` after a pending `FF`;
  - a pending prefix followed by a word that takes none (`FE` before `F0` or before a non-`F` word, for example).
- R11: Any non-prefix word clears the pending state, whether it merged or was flagged invalid. The next word then decodes unprefixed.
- R12: `flush_i` forces `valid_o`=0, discards that cycle's word and clears the pending state.
- R13: Cycles with `valid_i`=0 keep the pending payloads, so a prefix still merges across idle gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction word present this cycle |
| flush_i | input | 1 | Pipeline flush: drop word and pending prefixes |
| word_i | input | 32 | Instruction word from decode |
| valid_o | output | 1 | Slot issued to execute |
| bubble_o | output | 1 | Slot is a prefix no-operation |
| irq_ok_o | output | 1 | Interrupt may be taken at this slot |
| illegal_o | output | 1 | Invalid prefix combination |
| kind_o | output | 3 | 0 none, 1 plain, 2 immediate op, 3 move to R0, 4 absolute jump, 5 absolute call |
| imm_o | output | 64 | Assembled immediate or target |
| opx_valid_o | output | 1 | Opcode extension attached |
| opx_o | output | 24 | Opcode extension payload |

## Verification
The hardest behaviour to reach from the ports is pending state that has to survive or die across the surrounding cycles. Examples are a prefix held through an idle gap, a chain broken by a flush, and a third prefix arriving on a full chain. The stimulus therefore runs as one unbroken stream with no resets between entries. Each chain is built from the words before it, and the word after every invalid or flushed case is checked to confirm that it decodes with no prefix. A final directed case applies reset in the middle of a chain.

// File: rtl/jc_pkg.sv
package jc_pkg;
  localparam int WORD_W    = 32;
  localparam int PAY_W     = 24;
  localparam int IMM_W     = 64;
  localparam int SHORT_W   = 9;
  localparam int I16_W     = 16;
  localparam int WIDE_W    = PAY_W + SHORT_W;
  localparam int MAX_CHAIN = 2;
  localparam int CNT_W     = $clog2(MAX_CHAIN + 1);
  localparam int TOP_W     = IMM_W - 2 * PAY_W;

  localparam logic [7:0] B_R3   = 8'hF0;
  localparam logic [7:0] B_LS   = 8'hF1;
  localparam logic [7:0] B_ALU  = 8'hF2;
  localparam logic [7:0] B_I16  = 8'hF8;
  localparam logic [7:0] B_MOVU = 8'hFA;
  localparam logic [7:0] B_MOVN = 8'hFB;
  localparam logic [7:0] B_PIMM = 8'hFE;
  localparam logic [7:0] B_POPC = 8'hFF;

  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_PLAIN = 3'd1,
    K_IMM   = 3'd2,
    K_MOVR0 = 3'd3,
    K_JMP   = 3'd4,
    K_CALL  = 3'd5
  } kind_e;

  typedef enum logic [3:0] {
    C_OTHER, C_R3, C_LS, C_ALU, C_I16, C_MOVU, C_MOVN, C_PIMM, C_POPC
  } cls_e;
endpackage

// File: rtl/jc_classify.sv
module jc_classify
  import jc_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output cls_e              cls_o
);
  always_comb begin
    unique case (word_i[WORD_W-1 -: 8])
      B_R3:    cls_o = C_R3;
      B_LS:    cls_o = C_LS;
      B_ALU:   cls_o = C_ALU;
      B_I16:   cls_o = C_I16;
      B_MOVU:  cls_o = C_MOVU;
      B_MOVN:  cls_o = C_MOVN;
      B_PIMM:  cls_o = C_PIMM;
      B_POPC:  cls_o = C_POPC;
      default: cls_o = C_OTHER;
    endcase
  end
endmodule

// File: rtl/jc_state.sv
module jc_state
  import jc_pkg::*;
(
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           take_i,
  input  logic                           clear_i,
  input  logic                           take_opx_i,
  input  logic [PAY_W-1:0]               pay_i,
  output logic [CNT_W-1:0]               cnt_o,
  output logic                           opx_o,
  output logic [MAX_CHAIN-1:0][PAY_W-1:0] pay_o
);
  logic [CNT_W-1:0]                cnt_q;
  logic                            opx_q;
  logic [MAX_CHAIN-1:0][PAY_W-1:0] pay_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      opx_q <= 1'b0;
      pay_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
      opx_q <= 1'b0;
      pay_q <= '0;
    end else if (take_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
      opx_q <= take_opx_i;
      for (int i = 0; i < MAX_CHAIN; i++) begin
        if (cnt_q == CNT_W'(i)) pay_q[i] <= pay_i;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign opx_o = opx_q;
  assign pay_o = pay_q;
endmodule

// File: rtl/jc_merge.sv
module jc_merge
  import jc_pkg::*;
(
  input  cls_e              cls_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              opx_i,
  input  logic [PAY_W-1:0]  p0_i,
  input  logic [PAY_W-1:0]  p1_i,
  output kind_e             kind_o,
  output logic [IMM_W-1:0]  imm_o,
  output logic              ill_o,
  output logic              opxv_o
);
  logic [IMM_W-1:0]  sx9, sx16, sx33, full64, mov24, mov48, tgt48;
  logic [WIDE_W-1:0] wide;
  logic              neg;

  assign neg    = (cls_i == C_MOVN);
  assign wide   = {p0_i, word_i[SHORT_W-1:0]};
  assign sx9    = {{(IMM_W-SHORT_W){word_i[SHORT_W-1]}}, word_i[SHORT_W-1:0]};
  assign sx16   = {{(IMM_W-I16_W){word_i[I16_W-1]}}, word_i[I16_W-1:0]};
  assign sx33   = {{(IMM_W-WIDE_W){wide[WIDE_W-1]}}, wide};
  assign full64 = {p0_i, p1_i, word_i[I16_W-1:0]};
  assign mov24  = {{(IMM_W-PAY_W){neg}}, word_i[PAY_W-1:0]};
  assign mov48  = {{TOP_W{neg}}, p0_i, word_i[PAY_W-1:0]};
  assign tgt48  = {{TOP_W{1'b0}}, p0_i, word_i[PAY_W-1:0]};

  always_comb begin
    kind_o = K_NONE;
    imm_o  = '0;
    ill_o  = 1'b0;
    opxv_o = 1'b0;
    unique case (cls_i)
      C_R3: begin
        if (cnt_i == '0) kind_o = K_PLAIN;
        else if (cnt_i == CNT_W'(1) && opx_i) begin
          kind_o = K_PLAIN;
          opxv_o = 1'b1;
        end else ill_o = 1'b1;
      end
      C_LS, C_ALU: begin
        if (cnt_i == '0) begin
          kind_o = K_IMM;
          imm_o  = sx9;
        end else if (cnt_i == CNT_W'(1)) begin
          kind_o = K_IMM;
          imm_o  = opx_i ? sx9 : sx33;
          opxv_o = opx_i;
        end else ill_o = 1'b1;  // 57-bit form unsupported
      end
      C_I16: begin
        if (cnt_i == '0) begin
          kind_o = K_IMM;
          imm_o  = sx16;
        end else if (cnt_i == CNT_W'(1) && opx_i) begin
          kind_o = K_IMM;
          imm_o  = sx16;
          opxv_o = 1'b1;
        end else if (cnt_i == CNT_W'(MAX_CHAIN)) begin
          kind_o = K_IMM;
          imm_o  = full64;
        end else ill_o = 1'b1;
      end
      C_MOVU, C_MOVN: begin
        if (cnt_i == '0) begin
          kind_o = K_MOVR0;
          imm_o  = mov24;
        end else if (cnt_i == CNT_W'(1)) begin
          kind_o = opx_i ? (neg ? K_CALL : K_JMP) : K_MOVR0;
          imm_o  = opx_i ? tgt48 : mov48;
        end else ill_o = 1'b1;
      end
      C_OTHER: begin
        if (cnt_i == '0) kind_o = K_PLAIN;
        else ill_o = 1'b1;
      end
      default: ill_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/jumbo_combiner.sv
module jumbo_combiner
  import jc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic        flush_i,
  input  logic [31:0] word_i,
  output logic        valid_o,
  output logic        bubble_o,
  output logic        irq_ok_o,
  output logic        illegal_o,
  output logic [2:0]  kind_o,
  output logic [63:0] imm_o,
  output logic        opx_valid_o,
  output logic [23:0] opx_o
);
  cls_e                            cls;
  logic [CNT_W-1:0]                cnt_q;
  logic                            opx_q;
  logic [MAX_CHAIN-1:0][PAY_W-1:0] pay_q;
  kind_e                           m_kind;
  logic [IMM_W-1:0]                m_imm;
  logic                            m_ill, m_opxv;
  logic                            fire, is_pfx, pfx_ok, take, clear, issue_ok;

  jc_classify u_cls (.word_i(word_i), .cls_o(cls));

  assign fire   = valid_i & ~flush_i;
  assign is_pfx = (cls == C_PIMM) | (cls == C_POPC);
  // second link only for immediate chains; no form consumes two opcode prefixes
  assign pfx_ok = is_pfx & ((cnt_q == '0) |
                  ((cnt_q < CNT_W'(MAX_CHAIN)) & ~opx_q & (cls == C_PIMM)));
  assign take   = fire & pfx_ok;
  assign clear  = flush_i | (fire & ~pfx_ok);

  jc_state u_st (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_i    (take),
    .clear_i   (clear),
    .take_opx_i(cls == C_POPC),
    .pay_i     (word_i[PAY_W-1:0]),
    .cnt_o     (cnt_q),
    .opx_o     (opx_q),
    .pay_o     (pay_q)
  );

  jc_merge u_mg (
    .cls_i (cls),
    .word_i(word_i),
    .cnt_i (cnt_q),
    .opx_i (opx_q),
    .p0_i  (pay_q[0]),
    .p1_i  (pay_q[1]),
    .kind_o(m_kind),
    .imm_o (m_imm),
    .ill_o (m_ill),
    .opxv_o(m_opxv)
  );

  assign issue_ok    = fire & ~is_pfx & ~m_ill;
  assign valid_o     = fire;
  assign bubble_o    = take;
  assign irq_ok_o    = fire & ~pfx_ok;
  assign illegal_o   = fire & (is_pfx ? ~pfx_ok : m_ill);
  assign kind_o      = issue_ok ? m_kind : K_NONE;
  assign imm_o       = issue_ok ? m_imm : '0;
  assign opx_valid_o = issue_ok & m_opxv;
  assign opx_o       = (issue_ok & m_opxv) ? pay_q[0] : '0;
endmodule

// File: rtl/jc_chk.sv
module jc_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic        flush_i,
  input logic [31:0] word_i,
  input logic        valid_o,
  input logic        bubble_o,
  input logic        irq_ok_o,
  input logic        illegal_o,
  input logic [2:0]  kind_o,
  input logic [63:0] imm_o,
  input logic [1:0]  cnt_i
);
  logic fire, pfx_word;
  assign fire     = valid_i & ~flush_i;
  assign pfx_word = (word_i[31:25] == 7'h7F);

  a_r2_bubble_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bubble_o |-> (!irq_ok_o && kind_o == 3'd0 && !illegal_o));
  a_r4_target_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_o == 3'd4 || kind_o == 3'd5) |-> (imm_o[63:48] == 16'h0));
  a_r9_no_57bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && cnt_i == 2'd2 && (word_i[31:24] == 8'hF1 || word_i[31:24] == 8'hF2)) |-> illegal_o);
  a_r10_third_prefix: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && pfx_word && cnt_i == 2'd2) |-> (illegal_o && !bubble_o));
  a_r11_clear_after_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !pfx_word) |=> (cnt_i == 2'd0));
  a_r12_flush_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !valid_o ##1 (cnt_i == 2'd0));
  a_r13_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !flush_i) |=> $stable(cnt_i));
endmodule

bind jumbo_combiner jc_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .flush_i  (flush_i),
  .word_i   (word_i),
  .valid_o  (valid_o),
  .bubble_o (bubble_o),
  .irq_ok_o (irq_ok_o),
  .illegal_o(illegal_o),
  .kind_o   (kind_o),
  .imm_o    (imm_o),
  .cnt_i    (cnt_q)
);

// File: tb/sim_jumbo_combiner.sv
module sim_jumbo_combiner;
  typedef struct packed {
    logic        fl;
    logic        vi;
    logic [31:0] w;
    logic        vo;
    logic        bo;
    logic        io;
    logic        il;
    logic [2:0]  k;
    logic [63:0] imm;
    logic        ov;
    logic [23:0] ox;
    logic [3:0]  req;
  } vec_t;

  localparam int N = 45;
  localparam vec_t VEC [N] = '{
    '{0,1,32'hF20001FF, 1,0,1,0,3'd2,64'hFFFFFFFFFFFFFFFF,0,24'h0,4'd7},  // R7
    '{0,1,32'hF1000045, 1,0,1,0,3'd2,64'h0000000000000045,0,24'h0,4'd7},  // R7
    '{0,1,32'hF8008000, 1,0,1,0,3'd2,64'hFFFFFFFFFFFF8000,0,24'h0,4'd7},  // R7
    '{0,1,32'hFA123456, 1,0,1,0,3'd3,64'h0000000000123456,0,24'h0,4'd7},  // R7
    '{0,1,32'hFB123456, 1,0,1,0,3'd3,64'hFFFFFFFFFF123456,0,24'h0,4'd7},  // R7
    '{0,1,32'hFEABCDEF, 1,1,0,0,3'd0,64'h0,0,24'h0,4'd2},                 // R2
    '{0,1,32'hFA012345, 1,0,1,0,3'd3,64'h0000ABCDEF012345,0,24'h0,4'd3},  // R3
    '{0,1,32'hFE000001, 1,1,0,0,3'd0,64'h0,0,24'h0,4'd2},
    '{0,1,32'hFB000002, 1,0,1,0,3'd3,64'hFFFF000001000002,0,24'h0,4'd3},  // R3
    '{0,1,32'hFF123456, 1,1,0,0,3'd0,64'h0,0,24'h0,4'd2},
    '{0,1,32'hFA789ABC, 1,0,1,0,3'd4,64'h0000123456789ABC,0,24'h0,4'd4},  // R4
    '{0,1,32'hFF00FFFF, 1,1,0,0,3'd0,64'h0,0,24'h0,4'd2},
    '{0,1,32'hFB000010, 1,0,1,0,3'd5,64'h000000FFFF000010,0,24'h0,4'd4},  // R4
    '{0,1,32'hFEABCDEF, 1,1,0,0,3'd0,64'h0,0,24'h0,4'd5},
    '{0,1,32'hFE012345, 1,1,0,0,3'd0,64'h0,0,24'h0,4'd5},
    '{0,1,32'hF8116789, 1,0,1,0,3'd2,64'hABCDEF0123456789,0,24'h0,4'd5},  // R5
    '{0,1,32'hFE800000, 1,1,0,0,3'd0,64'h0,0,24'h0,4'd6},
    '{0,1,32'hF20001FF, 1,0,1,0,3'd2,64'hFFFFFFFF000001FF,0,24'h0,4'd6},  // R6
    '{0,1,32'hFE000123, 1,1,0,0,3'd0,64'h0,0,24'h0,4'd6},
    '{0,1,32'hF1000005, 1,0,1,0,3'd2,64'h0000000000024605,0,24'h0,4'd6},  // R6
    '{0,1,32'hFF00ABCD, 1,1,0,0,3'd0,64'h0,0,24'h0,4'd8},
    '{0,1,32'hF0001234, 1,0,1,0,3'd1,64'h0,1,24'h00ABCD,4'd8},            // R8
    '{0,1,32'hF0001234, 1,0,1,0,3'd1,64'h0,0,24'h0,4'd11},                // R11
    '{0,1,32'hFE000001, 1,1,0,0,3'd0,64'h0,0,24'h0,4'd9},
    '{0,1,32'hFE000002, 1,1,0,0,3'd0,64'h0,0,24'h0,4'd9},
    '{0,1,32'hF2000003, 1,0,1,1,3'd0,64'h0,0,24'h0,4'd9},                 // R9
    '{0,1,32'hF2000003, 1,0,1,0,3'd2,64'h3,0,24'h0,4'd11},                // R11
    '{0,1,32'hFE000001, 1,1,0,0,3'd0,64'h0,0,24'h0,4'd10},
    '{0,1,32'hFE000002, 1,1,0,0,3'd0,64'h0,0,24'h0,4'd10},
    '{0,1,32'hFE000003, 1,0,1,1,3'd0,64'h0,0,24'h0,4'd10},                // R10 third
    '{0,1,32'hFA000007, 1,0,1,0,3'd3,64'h7,0,24'h0,4'd10},
    '{0,1,32'hFE000001, 1,1,0,0,3'd0,64'h0,0,24'h0,4'd10},
    '{0,1,32'hFF000002, 1,0,1,1,3'd0,64'h0,0,24'h0,4'd10},                // R10 mixed
    '{0,1,32'hFA000007, 1,0,1,0,3'd3,64'h7,0,24'h0,4'd10},
    '{0,1,32'hFE000005, 1,1,0,0,3'd0,64'h0,0,24'h0,4'd10},
    '{0,1,32'hF0000000, 1,0,1,1,3'd0,64'h0,0,24'h0,4'd10},                // R10 no taker
    '{0,1,32'hFE000005, 1,1,0,0,3'd0,64'h0,0,24'h0,4'd13},
    '{0,0,32'h00000000, 0,0,0,0,3'd0,64'h0,0,24'h0,4'd13},                // R13 idle
    '{0,1,32'hFA000001, 1,0,1,0,3'd3,64'h0000000005000001,0,24'h0,4'd13}, // R13
    '{0,1,32'hFF000007, 1,1,0,0,3'd0,64'h0,0,24'h0,4'd12},
    '{1,1,32'hFA000001, 0,0,0,0,3'd0,64'h0,0,24'h0,4'd12},                // R12
    '{0,1,32'hFA000001, 1,0,1,0,3'd3,64'h1,0,24'h0,4'd12},                // R12
    '{0,1,32'h12345678, 1,0,1,0,3'd1,64'h0,0,24'h0,4'd7},                 // R7 other
    '{0,1,32'hFE000001, 1,1,0,0,3'd0,64'h0,0,24'h0,4'd10},
    '{0,1,32'h12345678, 1,0,1,1,3'd0,64'h0,0,24'h0,4'd10}                 // R10
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0, flush_i = 1'b0;
  logic [31:0] word_i = '0;
  logic        valid_o, bubble_o, irq_ok_o, illegal_o, opx_valid_o;
  logic [2:0]  kind_o;
  logic [63:0] imm_o;
  logic [23:0] opx_o;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  jumbo_combiner u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .flush_i(flush_i),
    .word_i(word_i), .valid_o(valid_o), .bubble_o(bubble_o),
    .irq_ok_o(irq_ok_o), .illegal_o(illegal_o), .kind_o(kind_o),
    .imm_o(imm_o), .opx_valid_o(opx_valid_o), .opx_o(opx_o)
  );

  task automatic check(input int req, input logic [95:0] exp);
    logic [95:0] got;
    got = {valid_o, bubble_o, irq_ok_o, illegal_o, kind_o, imm_o, opx_valid_o, opx_o};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d got %h exp %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic fl, input logic vi, input logic [31:0] w);
    @(negedge clk);
    flush_i = fl;
    valid_i = vi;
    word_i  = w;
    #3;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check(1, 96'h0);  // R1 idle outputs in reset
    rst_ni = 1'b1;
    for (int i = 0; i < N; i++) begin
      drive(VEC[i].fl, VEC[i].vi, VEC[i].w);
      check(int'(VEC[i].req), {VEC[i].vo, VEC[i].bo, VEC[i].io, VEC[i].il,
                               VEC[i].k, VEC[i].imm, VEC[i].ov, VEC[i].ox});
    end
    // R1: reset in the middle of a chain drops the pending payload
    drive(1'b0, 1'b1, 32'hFE000009);
    check(2, {1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 64'h0, 1'b0, 24'h0});
    @(negedge clk);
    valid_i = 1'b0;
    rst_ni = 1'b0;
    #2;
    rst_ni = 1'b1;
    drive(1'b0, 1'b1, 32'hFA000009);
    check(1, {1'b1, 1'b0, 1'b1, 1'b0, 3'd3, 64'h9, 1'b0, 24'h0});
    drive(1'b0, 1'b0, 32'h0);
    check(1, 96'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule